// File: doc/BRIEF.md
# Write-Once Keepalive Watchdog Timer

This block is a watchdog timer with a single 32-bit register on a simple valid/address/data port. The first write to the register sets the timeout: a 12-bit reload count, a run enable, a choice of a slow time base and a 2-bit mode code. That setting can never change again until reset. Every later write to the register, whatever data it carries, is a keepalive: it reloads the down-counter from the stored count and starts the time base over.

The counter is clocked by an internal enable that fires on every second bus clock cycle. When the slow time base is selected, a further divider (16384 by default) sits between that enable and the counter. When the counter is at zero and another decrement is due, the block raises a timeout interrupt that stays high until reset. System software uses that interrupt to start a restart.

Top module: `keepalive_wdt`

## Requirements
- R1: After reset the timeout interrupt is low, and a read of offset 0x0 returns all zeros (not configured).
- R2: The first write to offset 0x0 stores data bits [11:0] as the reload count, bit 12 as the slow time base select, bit 13 as the run enable and bits [15:14] as the mode code. From then on a read of offset 0x0 returns those 16 bits in [15:0], a 1 in bit 31 and zeros in bits [30:16].
- R3: Writes to offset 0x0 after the first one leave the stored setting unchanged, whatever their data.
- R4: Every write to offset 0x0 reloads the counter from the stored count and restarts the time base. The timeout is then measured from the latest write.
- R5: With the slow time base off, a reload count of N and the run enable set, the interrupt is low through clock edge 2(N+1)-1 after the write edge and high from edge 2(N+1) on.
- R6: With the slow time base on, every decrement takes PRESCALE_DIV timer ticks. The interrupt rises at edge 2·PRESCALE_DIV·(N+1) after the write edge.
- R7: With the run enable clear, the counter does not run and the interrupt never rises, even after keepalive writes.
- R8: Once high, the interrupt stays high until reset, even across keepalive writes.
- R9: Writes to any other offset, and read transfers (write flag low) to offset 0x0, have no effect. A read of any other offset returns zero.
- R10: A reload count of zero times out on the first decrement tick, at edge 2 after the write edge when the slow time base is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Transfer valid |
| bus_write | input | 1 | 1 for a write transfer, 0 for a read |
| bus_addr | input | ADDR_W | Byte offset of the transfer |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current offset (combinational) |
| irq_out | output | 1 | Sticky timeout interrupt |

## Verification
If the lock flag or the stored setting is corrupted, the read of offset 0x0 shows it on the first cycle after the write that caused it. A keepalive that changes the setting is caught by the next read. Errors in the counter, the half-rate phase or the divider only show as an interrupt edge at the wrong cycle, so the timing checks sample the interrupt both on the last cycle before the expected timeout and on the timeout cycle itself. A missed reload shows up as an early timeout after a keepalive. A time base that ignores the select shows up as a timeout tens of thousands of cycles too early.

// File: rtl/wdt_once_pkg.sv
package wdt_once_pkg;

   localparam int RELOAD_W = 12;
   localparam int CFG_W    = 16;
   localparam int DATA_W   = 32;

   // Field layout of the setting word; software encodes to these positions.
   typedef struct packed {
      logic [1:0]          mode;      // [15:14]
      logic                run_en;    // [13]
      logic                slow_sel;  // [12]
      logic [RELOAD_W-1:0] reload;    // [11:0]
   } wdt_cfg_t;

endpackage

// File: rtl/wdt_reg_lock.sv
module wdt_reg_lock
   import wdt_once_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int REG_OFFSET = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                valid,
   input  logic                write,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wdata,
   output wdt_cfg_t            cfg_q,
   output logic                cfg_done,
   output logic                load,
   output logic [RELOAD_W-1:0] load_val,
   output logic                load_run,
   output logic [DATA_W-1:0]   rdata
);

   localparam logic [ADDR_W-1:0] OFS = ADDR_W'(REG_OFFSET);
   localparam int PAD_W = DATA_W - CFG_W - 1;

   wdt_cfg_t new_cfg;
   logic     sel;
   logic     unused_wdata_hi;

   assign new_cfg         = wdt_cfg_t'(wdata[CFG_W-1:0]);
   assign unused_wdata_hi = ^wdata[DATA_W-1:CFG_W];
   assign sel             = (addr == OFS);
   assign load            = valid && write && sel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q    <= '0;
         cfg_done <= 1'b0;
      end else if (load && !cfg_done) begin
         cfg_q    <= new_cfg;
         cfg_done <= 1'b1;
      end
   end

   // First write takes its own data; later writes use the locked copy.
   assign load_val = cfg_done ? cfg_q.reload : new_cfg.reload;
   assign load_run = cfg_done ? cfg_q.run_en : new_cfg.run_en;

   assign rdata = sel ? {cfg_done, {PAD_W{1'b0}}, cfg_q} : '0;

endmodule

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
   parameter int PRESCALE_DIV  = 16384,
   parameter bit HAS_PRESCALER = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic slow_sel,
   output logic dec_tick
);

   logic ph_q;

   always_ff @(posedge clk) begin
      if (!rst_n || restart) ph_q <= 1'b0;
      else                   ph_q <= ~ph_q;
   end

   generate
      if (HAS_PRESCALER) begin : g_pre
         if (PRESCALE_DIV < 2) begin : g_bad_div
            $error("wdt_tick_gen: PRESCALE_DIV must be at least 2");
         end
         localparam int PW = $clog2(PRESCALE_DIV);
         localparam logic [PW-1:0] LAST = PW'(PRESCALE_DIV - 1);
         logic [PW-1:0] pre_q;

         always_ff @(posedge clk) begin
            if (!rst_n || restart) pre_q <= '0;
            else if (ph_q)         pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
         end

         assign dec_tick = ph_q && (!slow_sel || (pre_q == LAST));
      end else begin : g_nopre
         logic unused_sel;
         assign unused_sel = slow_sel;
         assign dec_tick   = ph_q;
      end
   endgenerate

endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             load_run,
   input  logic             dec_tick,
   output logic [CNT_W-1:0] cnt_q,
   output logic             running_q,
   output logic             expired_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         running_q <= 1'b0;
         expired_q <= 1'b0;
      end else if (load) begin
         cnt_q     <= load_val;
         running_q <= load_run;
      end else if (running_q && dec_tick) begin
         if (cnt_q == '0) begin
            running_q <= 1'b0;
            expired_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

endmodule

// File: rtl/keepalive_wdt.sv
module keepalive_wdt
   import wdt_once_pkg::*;
#(
   parameter int ADDR_W        = 8,
   parameter int REG_OFFSET    = 0,
   parameter int PRESCALE_DIV  = 16384,
   parameter bit HAS_PRESCALER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq_out
);

   if (ADDR_W < 2) begin : g_bad_addr_w
      $error("keepalive_wdt: ADDR_W must be at least 2");
   end
   if ((REG_OFFSET % 4) != 0 || REG_OFFSET >= (1 << ADDR_W)) begin : g_bad_ofs
      $error("keepalive_wdt: REG_OFFSET must be word aligned and in range");
   end

   wdt_cfg_t            cfg_q;
   logic [CFG_W-1:0]    cfg_bits;
   logic                cfg_done;
   logic                wr_hit;
   logic [RELOAD_W-1:0] load_val;
   logic                load_run;
   logic                dec_tick;
   logic [RELOAD_W-1:0] cnt_q;
   logic                running_q;

   assign cfg_bits = cfg_q;

   wdt_reg_lock #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_reg (
      .clk(clk), .rst_n(rst_n), .valid(bus_valid), .write(bus_write),
      .addr(bus_addr), .wdata(bus_wdata), .cfg_q(cfg_q), .cfg_done(cfg_done),
      .load(wr_hit), .load_val(load_val), .load_run(load_run), .rdata(bus_rdata)
   );

   wdt_tick_gen #(.PRESCALE_DIV(PRESCALE_DIV), .HAS_PRESCALER(HAS_PRESCALER)) u_tick (
      .clk(clk), .rst_n(rst_n), .restart(wr_hit), .slow_sel(cfg_q.slow_sel),
      .dec_tick(dec_tick)
   );

   wdt_down_counter #(.CNT_W(RELOAD_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(wr_hit), .load_val(load_val),
      .load_run(load_run), .dec_tick(dec_tick), .cnt_q(cnt_q),
      .running_q(running_q), .expired_q(irq_out)
   );

endmodule

// File: rtl/wdt_once_chk.sv
module wdt_once_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_hit,
   input logic        cfg_done,
   input logic [15:0] cfg_bits,
   input logic [11:0] cnt_q,
   input logic        running_q,
   input logic        irq,
   input logic [31:0] wdata
);

   p_irq_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_done |-> !irq);

   p_first_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !cfg_done) |=> (cfg_done && cfg_bits == $past(wdata[15:0])));

   p_cfg_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_done |=> (cfg_done && $stable(cfg_bits)));

   p_keepalive_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && cfg_done) |=> (cnt_q == cfg_bits[11:0]));

   p_expire_from_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(running_q) && $past(cnt_q) == 12'd0));

   p_halted_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!running_q && !wr_hit) |=> $stable(cnt_q));

   p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> irq);

endmodule

bind keepalive_wdt wdt_once_chk u_chk (
   .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .cfg_done(cfg_done),
   .cfg_bits(cfg_bits), .cnt_q(cnt_q), .running_q(running_q),
   .irq(irq_out), .wdata(bus_wdata)
);

// File: tb/tb_keepalive_wdt.sv
module tb_keepalive_wdt;

   localparam int D = 16384;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_out;

   always #5 clk = ~clk;

   keepalive_wdt dut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_out(irq_out)
   );

   typedef struct {
      int          cyc;
      logic        irq;
      logic        chk_rd;
      logic [31:0] rd;
      string       req;
   } item_t;

   item_t q[$];
   int cyc = 0;
   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // Monitor: sample shortly after each edge, pop due items and compare.
   always @(posedge clk) begin
      #2;
      while (q.size() > 0 && q[0].cyc <= cyc) begin
         item_t it;
         it = q.pop_front();
         total++;
         if (it.cyc != cyc) begin
            bad++;
            $display("FAIL %s: check missed, cycle %0d expected %0d", it.req, cyc, it.cyc);
         end else begin
            if (irq_out !== it.irq) begin
               bad++;
               $display("FAIL %s: irq_out=%b expected %b at cycle %0d", it.req, irq_out, it.irq, cyc);
            end
            if (it.chk_rd && bus_rdata !== it.rd) begin
               bad++;
               $display("FAIL %s: rdata=%h expected %h at cycle %0d", it.req, bus_rdata, it.rd, cyc);
            end
         end
      end
   end

   task automatic expect_at(input int ofs, input logic irq, input logic chk,
                            input logic [31:0] rd, input string req);
      item_t it;
      it.cyc = cyc + ofs; it.irq = irq; it.chk_rd = chk; it.rd = rd; it.req = req;
      q.push_back(it);
   endtask

   task automatic drain();
      while (q.size() > 0) @(negedge clk);
   endtask

   task automatic do_reset();
      drain();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic xfer(input logic wr, input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
   endtask

   task automatic peek(input logic [7:0] a, input logic exp_irq,
                       input logic [31:0] rd, input string req);
      bus_addr = a;
      expect_at(1, exp_irq, 1'b1, rd, req);
      @(negedge clk);
      bus_addr = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      do_reset();
      expect_at(1, 1'b0, 1'b1, 32'h0, "R1");
      drain();

      // R2/R5: reload 5, fast base, mode 2; upper data bits are not stored
      xfer(1'b1, 8'h00, 32'hDEAD_A005);
      expect_at(1, 1'b0, 1'b1, 32'h8000_A005, "R2");
      expect_at(11, 1'b0, 1'b0, 32'h0, "R5 before timeout");
      expect_at(12, 1'b1, 1'b0, 32'h0, "R5 timeout edge");
      drain();
      // R3/R8: keepalive with other data after timeout
      xfer(1'b1, 8'h00, 32'h0000_1FFF);
      expect_at(1, 1'b1, 1'b1, 32'h8000_A005, "R3");
      expect_at(30, 1'b1, 1'b0, 32'h0, "R8");
      drain();

      // R4: reload 3, keepalive after 4 cycles moves the timeout
      do_reset();
      xfer(1'b1, 8'h00, 32'h0000_2003);
      repeat (4) @(negedge clk);
      xfer(1'b1, 8'h00, 32'hFFFF_FFFF);
      expect_at(1, 1'b0, 1'b1, 32'h8000_2003, "R3 keepalive data ignored");
      expect_at(7, 1'b0, 1'b0, 32'h0, "R4 no early timeout");
      expect_at(8, 1'b1, 1'b0, 32'h0, "R4 timeout from keepalive");
      drain();

      // R10: reload zero
      do_reset();
      xfer(1'b1, 8'h00, 32'h0000_A000);
      expect_at(1, 1'b0, 1'b0, 32'h0, "R10 before");
      expect_at(2, 1'b1, 1'b0, 32'h0, "R10 timeout");
      drain();

      // R7: run enable clear
      do_reset();
      xfer(1'b1, 8'h00, 32'h0000_8002);
      expect_at(1, 1'b0, 1'b1, 32'h8000_8002, "R2 disabled setting");
      expect_at(40, 1'b0, 1'b0, 32'h0, "R7 idle");
      drain();
      xfer(1'b1, 8'h00, 32'h0000_A000);
      expect_at(40, 1'b0, 1'b1, 32'h8000_8002, "R7 after keepalive");
      drain();

      // R9: other offsets and read transfers
      do_reset();
      xfer(1'b1, 8'h04, 32'h0000_A000);
      xfer(1'b0, 8'h00, 32'h0000_A000);
      expect_at(10, 1'b0, 1'b1, 32'h0, "R9 not configured");
      drain();
      xfer(1'b1, 8'h00, 32'h0000_A001);
      peek(8'h04, 1'b0, 32'h0, "R9 other offset reads zero");
      expect_at(2, 1'b0, 1'b0, 32'h0, "R5 reload 1 before");
      expect_at(3, 1'b1, 1'b0, 32'h0, "R5 reload 1 timeout");
      drain();

      // R6: slow time base, reload 0
      do_reset();
      xfer(1'b1, 8'h00, 32'h0000_3000);
      expect_at(1, 1'b0, 1'b1, 32'h8000_3000, "R2 slow setting");
      expect_at(2, 1'b0, 1'b0, 32'h0, "R6 no fast timeout");
      expect_at(2*D - 1, 1'b0, 1'b0, 32'h0, "R6 before");
      expect_at(2*D, 1'b1, 1'b0, 32'h0, "R6 timeout");
      drain();

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule